// File: doc/BRIEF.md
# Valley-Switching Gate Timing Controller

This block decides when the main switch of a quasi-resonant flyback converter turns on and when it turns off. While the gate is low, it counts the valleys of the drain ringing. Each valley arrives as a one-cycle zero-crossing pulse from an external detector. The gate turns on once the count reaches a load-dependent target supplied by a separate frequency-reduction block. The controller ignores all valleys for a ringing-suppression interval after turn-off. The length of that interval depends on a level flag from the zero-crossing sense path. A maximum off time forces a turn-on when the ringing dies away too soon to produce enough valleys.

While the gate is high, the block ignores the regulation comparator and the peak current-limit comparator for a leading-edge blanking interval. After that interval, either comparator turns the gate off. A maximum on time ends any pulse that neither comparator stops. All intervals are parameters counted in clock cycles. The analog comparators and sensing are outside the block and arrive as synchronous flags.

Top module: `qr_valley_gate`

## Requirements
- R1: While `rst_n` is low, `gate` is low. The first clock cycle after reset is the first cycle of an off period, with the valley count at zero.
- R2: While `ring_hi` is 1, `gate` stays low for at least `SUPP_SHORT` cycles after it falls. If `valley_target` is 0, it rises after exactly `SUPP_SHORT` low cycles.
- R3: While `ring_hi` is 0, the suppression interval is `SUPP_LONG` cycles instead. The gate stays low at least that long, and with a satisfied target it rises after exactly that long.
- R4: During an off period, each cycle with `zc_pulse` high adds one to the valley count. Suppose the count reaches `valley_target` from a pulse in low cycle i (counting from 0). The gate then rises after max(i+2, suppression length) low cycles, capped at `OFF_MAX`.
- R5: The valley count saturates at `VALLEY_MAX` (7) and never wraps. Further pulses keep it at 7.
- R6: With the target never reached, `gate` rises after exactly `OFF_MAX` low cycles.
- R7: The valley count returns to zero each time `gate` rises. Valleys from one off period never count toward the next.
- R8: Zero-crossing pulses while `gate` is high are ignored.
- R9: During the first `LEB` high cycles, `cmp_trip` and `ilim_trip` are ignored. A trip held from turn-on gives exactly `LEB`+1 high cycles.
- R10: A trip on either `cmp_trip` or `ilim_trip` in high cycle k, where k ≥ `LEB`, makes `gate` fall after k+1 high cycles.
- R11: If no trip ends the pulse, `gate` falls after exactly `ON_MAX` high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zc_pulse | input | 1 | One valley detected this cycle |
| ring_hi | input | 1 | Ringing level above the suppression threshold (selects the short interval) |
| cmp_trip | input | 1 | Regulation comparator tripped |
| ilim_trip | input | 1 | Peak current-limit comparator tripped |
| valley_target | input | $clog2(VALLEY_MAX+1) | Valley count needed for turn-on, 0..VALLEY_MAX |
| gate | output | 1 | Gate drive request, high = switch on |

## Verification
The assertions assume the parameters are ordered sensibly: `LEB` below `ON_MAX`, and both suppression intervals no longer than `OFF_MAX`. They also assume every input is synchronous to `clk`, so a trip or a level is seen in whole cycles. The bench changes every input only on the falling clock edge and keeps `valley_target` within 0..7. It sweeps the target and the first-valley position over a small configuration whose intervals are a few cycles long. It predicts every low and high duration by arithmetic from the rules above.

// File: rtl/qr_valley_gate.sv
module qr_valley_gate #(
  parameter int SUPP_SHORT = 312,
  parameter int SUPP_LONG  = 3125,
  parameter int OFF_MAX    = 5250,
  parameter int LEB        = 41,
  parameter int ON_MAX     = 3750,
  parameter int VALLEY_MAX = 7,
  localparam int VW        = $clog2(VALLEY_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zc_pulse,
  input  logic          ring_hi,
  input  logic          cmp_trip,
  input  logic          ilim_trip,
  input  logic [VW-1:0] valley_target,
  output logic          gate
);

  localparam int TMAX = (OFF_MAX > ON_MAX) ? OFF_MAX : ON_MAX;
  localparam int TW   = $clog2(TMAX + 1);

  logic [TW-1:0] tmr;
  logic [VW-1:0] valleys;

  logic supp_done, enough, off_expire, turn_on;
  logic blank_done, trip, on_expire, turn_off;
  logic valley_full;

  assign supp_done   = ring_hi ? (tmr >= TW'(SUPP_SHORT - 1))
                               : (tmr >= TW'(SUPP_LONG - 1));
  assign enough      = valleys >= valley_target;
  assign off_expire  = tmr >= TW'(OFF_MAX - 1);
  assign turn_on     = !gate && ((supp_done && enough) || off_expire);

  assign blank_done  = tmr >= TW'(LEB);
  assign trip        = cmp_trip || ilim_trip;
  assign on_expire   = tmr >= TW'(ON_MAX - 1);
  assign turn_off    = gate && ((blank_done && trip) || on_expire);

  assign valley_full = valleys == VW'(VALLEY_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate    <= 1'b0;
      tmr     <= '0;
      valleys <= '0;
    end else begin
      if (turn_on || turn_off)
        tmr <= '0;
      else if (tmr != TW'(TMAX))
        tmr <= tmr + 1'b1;

      if (turn_on)
        gate <= 1'b1;
      else if (turn_off)
        gate <= 1'b0;

      if (turn_on)
        valleys <= '0;
      else if (!gate && zc_pulse && !valley_full)
        valleys <= valleys + 1'b1;
    end
  end

endmodule

module qr_valley_gate_chk #(
  parameter int SUPP_SHORT = 312,
  parameter int OFF_MAX    = 5250,
  parameter int LEB        = 41,
  parameter int ON_MAX     = 3750
) (
  input logic clk,
  input logic rst_n,
  input logic gate,
  input logic cmp_trip,
  input logic ilim_trip
);

  logic g_q;
  int   cnt_q;
  int   run_idx;

  assign run_idx = (gate == g_q) ? cnt_q + 1 : 0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_q   <= 1'b0;
      cnt_q <= -1;
    end else begin
      g_q   <= gate;
      cnt_q <= run_idx;
    end
  end

  // R1
  rst_low_chk: assert property (@(posedge clk) !rst_n |=> !gate);

  // R2
  supp_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && run_idx < SUPP_SHORT - 1) |=> !gate);

  // R6
  off_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && run_idx >= OFF_MAX - 1) |=> gate);

  // R9
  leb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && run_idx < LEB) |=> gate);

  // R10
  trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && run_idx >= LEB && (cmp_trip || ilim_trip)) |=> !gate);

  // R11
  on_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && run_idx >= ON_MAX - 1) |=> !gate);

endmodule

bind qr_valley_gate qr_valley_gate_chk #(
  .SUPP_SHORT(SUPP_SHORT), .OFF_MAX(OFF_MAX), .LEB(LEB), .ON_MAX(ON_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gate(gate), .cmp_trip(cmp_trip), .ilim_trip(ilim_trip)
);

// File: tb/tb_qr_valley_gate.sv
module tb_qr_valley_gate;

  localparam int S   = 4;
  localparam int L   = 12;
  localparam int OFF = 20;
  localparam int LB  = 3;
  localparam int ON  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zc_pulse = 1'b0, ring_hi = 1'b1, cmp_trip = 1'b0, ilim_trip = 1'b0;
  logic [2:0] valley_target = 3'd0;
  logic gate;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  qr_valley_gate #(
    .SUPP_SHORT(S), .SUPP_LONG(L), .OFF_MAX(OFF), .LEB(LB), .ON_MAX(ON), .VALLEY_MAX(7)
  ) dut (
    .clk(clk), .rst_n(rst_n), .zc_pulse(zc_pulse), .ring_hi(ring_hi),
    .cmp_trip(cmp_trip), .ilim_trip(ilim_trip), .valley_target(valley_target), .gate(gate)
  );

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_off(input int tgt, input bit ring, input int p, input int n);
    int sl = ring ? S : L;
    int v;
    if (tgt == 0) return sl;
    if (n < tgt) return OFF;
    v = p + tgt + 1;
    if (v < sl) v = sl;
    if (v > OFF) v = OFF;
    return v;
  endfunction

  function automatic int exp_on(input int tf);
    int v = (tf < LB) ? LB + 1 : tf + 1;
    return (v > ON) ? ON : v;
  endfunction

  // Starts at a falling edge in the first low cycle; returns at the first high cycle.
  task automatic off_phase(input int tgt, input bit ring, input int p, input int n, output int low);
    int idx = 0;
    valley_target = 3'(tgt);
    ring_hi = ring;
    forever begin
      zc_pulse = (idx >= p) && (idx < p + n);
      @(negedge clk);
      idx++;
      if (gate || idx > OFF + 5) break;
    end
    zc_pulse = 1'b0;
    low = idx;
  endtask

  task automatic on_phase(input int tf, input bit use_ilim, input bit pulses, output int high);
    int idx = 0;
    forever begin
      cmp_trip  = !use_ilim && (idx >= tf);
      ilim_trip = use_ilim && (idx >= tf);
      zc_pulse  = pulses;
      @(negedge clk);
      idx++;
      if (!gate || idx > ON + 5) break;
    end
    cmp_trip = 1'b0; ilim_trip = 1'b0; zc_pulse = 1'b0;
    high = idx;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    check(int'(gate), 0, "R1 gate low in reset");
    rst_n = 1'b1;
    // R1 and R6: the first off period starts at reset and has no valleys
    off_phase(7, 1'b1, 0, 0, d);
    check(d, OFF, "R1/R6 first off period");
    on_phase(ON + 2, 1'b0, 1'b0, d);
    check(d, ON, "R11 max on time");

    // R2 / R4 / R10 sweep over target, first valley position and trip point
    for (int t = 0; t <= 7; t++) begin
      for (int p = 0; p <= 6; p++) begin
        off_phase(t, 1'b1, p, 7, d);
        check(d, exp_off(t, 1'b1, p, 7), $sformatf("R4 t=%0d p=%0d", t, p));
        on_phase((t * 3 + p) % 18, p[0], 1'b0, d);
        check(d, exp_on((t * 3 + p) % 18), $sformatf("R10 tf=%0d", (t * 3 + p) % 18));
      end
    end

    // R2 target 0 on the short interval; R3 on the long interval
    off_phase(0, 1'b1, 0, 0, d);
    check(d, S, "R2 short suppression");
    on_phase(0, 1'b0, 1'b0, d);
    check(d, LB + 1, "R9 trip from turn-on");
    for (int t = 0; t <= 7; t++) begin
      off_phase(t, 1'b0, 1, 7, d);
      check(d, exp_off(t, 1'b0, 1, 7), $sformatf("R3 long suppression t=%0d", t));
      on_phase(LB, 1'b1, 1'b0, d);
      check(d, LB + 1, "R10 ilim right after blanking");
    end

    // R4: fewer valleys than the target
    for (int t = 1; t <= 7; t++) begin
      off_phase(t, 1'b1, 0, t - 1, d);
      check(d, OFF, $sformatf("R6 short of target t=%0d", t));
      on_phase(ON + 1, 1'b0, 1'b0, d);
      check(d, ON, "R11 max on time");
    end

    // R5: nine valleys during the long interval, target 7
    off_phase(7, 1'b0, 0, 9, d);
    check(d, L, "R5 saturation");
    on_phase(1, 1'b1, 1'b0, d);
    check(d, LB + 1, "R9 ilim within blanking");

    // R7: a fresh off period with no valleys must wait for max off time
    off_phase(1, 1'b1, 0, 0, d);
    check(d, OFF, "R7 count cleared at turn-on");

    // R8: valleys during on time are ignored
    on_phase(ON + 1, 1'b0, 1'b1, d);
    check(d, ON, "R11 with pulses while high");
    off_phase(1, 1'b1, 0, 0, d);
    check(d, OFF, "R8 pulses while high ignored");

    // R9 / R10 sweep of the trip point on both comparators
    for (int tf = 0; tf <= ON; tf++) begin
      on_phase(tf, tf[0], 1'b0, d);
      check(d, exp_on(tf), $sformatf("R9/R10 tf=%0d", tf));
      off_phase(0, 1'b1, 0, 0, d);
      check(d, S, "R2 short suppression");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule